// File: doc/BRIEF.md
# Four-Tributary Plesiochronous Frame Multiplexer

This block assembles a second- or third-order plesiochronous multiplex frame from four slower tributary bit streams and sends it as one serial bit per clock. A frame is four consecutive sets of equal length. The set length is a parameter: 212 bits for the lower order and 384 bits for the higher order. The layout is otherwise the same for both orders.

The first set opens with a ten-bit alignment word, then a remote alarm bit and a national-use bit. Every later position of that set carries tributary data, interleaved bit by bit. Sets 2, 3 and 4 each begin with four justification control bits, one per tributary. Set 4 then has four stuffing positions, again one per tributary. Each stuffing position carries either a real data bit or a dummy bit. The choice follows the stuff request that the tributary's elastic store gave at the start of Set 2.

Each tributary offers bits through a valid/ready pair. The block raises a tributary's ready in exactly the cycle in which it consumes that tributary's bit.

Top module: `pdh_frame_mux`

## Requirements
- R1: The frame is four sets of SET_BITS clocks each, sent in the order Set1, Set2, Set3, Set4 and then Set1 again. `frame_start` is high for exactly the one clock in which `line_bit` carries the first bit of Set 1.
- R2: Bits 1 to 10 of Set 1 carry the alignment word 1111010000, most significant bit first.
- R3: Bit 11 of Set 1 carries `alarm_bit` and bit 12 carries `national_bit`. Both inputs are sampled in the clock in which that position is assembled.
- R4: `line_bit` and `frame_start` are registered and appear one clock after the position is assembled. `trib_ready` is combinational and is high in the assembly clock of the slot it belongs to.
- R5: Every position that is not overhead carries tributary data. Tributary n (n = 1..4, `trib_*[n-1]`) owns the positions whose 1-based index within the set is congruent to n modulo 4. Data therefore begins with tributary 1 at bit 13 of Set 1, and with tributary 1 at the first data bit of Sets 2 to 4. In a data slot the bit sent is `trib_data[n-1]`, and `trib_ready[n-1]` is high.
- R6: Bit n (n = 1..4) of Sets 2, 3 and 4 is the justification control bit of tributary n. All three copies of it equal that tributary's stuff decision for the frame: 1 means stuff, 0 means no stuff.
- R7: Bit 4+n of Set 4 is the stuffing position of tributary n. When the decision is 0 it is a data slot (R5). When the decision is 1 it sends 1 and `trib_ready[n-1]` stays low.
- R8: `stuff_req[n-1]` is sampled at the clock edge that begins Set 2 and is held for the rest of the frame. Changes to it at any other time have no effect on the frame.
- R9: When a data slot is reached with `trib_valid` low for its tributary, the slot sends 1. `trib_ready` is still raised.
- R10: While `rst_n` is low, `line_bit`, `frame_start` and `trib_ready` are 0 and all stuff decisions are cleared. The first clock after reset assembles bit 1 of Set 1.
- R11: At most one bit of `trib_ready` is high in any clock. None is high during alignment, alarm, national or control positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_bit | input | 1 | Remote alarm value for bit 11 of Set 1 |
| national_bit | input | 1 | National-use value for bit 12 of Set 1 |
| trib_data | input | 4 | One offered data bit per tributary |
| trib_valid | input | 4 | Offered bit is valid, per tributary |
| trib_ready | output | 4 | Tributary bit consumed this clock |
| stuff_req | input | 4 | Per-tributary justification request for the frame |
| line_bit | output | 1 | Serial multiplexed output |
| frame_start | output | 1 | Marks the first bit of Set 1 on `line_bit` |

## Verification
The assertions check on every clock that at most one tributary is granted. They also check that no grant falls on alignment, alarm, national or control positions, that the stuffing positions grant exactly the tributaries that are not stuffing, and that the frame's stuff decisions change only at the entry to Set 2. They further check that the frame marker is a single-clock pulse that coincides with the first alignment bit. The exact bit content of every position needs the bench's cycle-by-cycle model: the alignment word order, the alarm and national bits, tributary data placement and rotation, the control bit copies, filler on underrun, and whether a request raised mid-frame is ignored.

// File: rtl/pdh_frame_mux.sv
module pdh_frame_mux #(
  parameter int         SET_BITS   = 212,
  parameter logic [9:0] ALIGN_WORD = 10'b1111010000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alarm_bit,
  input  logic       national_bit,
  input  logic [3:0] trib_data,
  input  logic [3:0] trib_valid,
  output logic [3:0] trib_ready,
  input  logic [3:0] stuff_req,
  output logic       line_bit,
  output logic       frame_start
);
  localparam int BW = $clog2(SET_BITS);

  logic [BW-1:0] bit_q;
  logic [1:0]    set_q;
  logic [3:0]    stuff_q;
  logic          line_q, fs_q, nxt_bit;

  wire       last_bit = (bit_q == BW'(SET_BITS - 1));
  wire [1:0] lane     = bit_q[1:0];
  wire [3:0] fas_idx  = 4'd9 - bit_q[3:0];

  wire in_fas   = (set_q == 2'd0) && (bit_q < BW'(10));
  wire in_alarm = (set_q == 2'd0) && (bit_q == BW'(10));
  wire in_nat   = (set_q == 2'd0) && (bit_q == BW'(11));
  wire in_ctrl  = (set_q != 2'd0) && (bit_q < BW'(4));
  wire in_stuff = (set_q == 2'd3) && (bit_q >= BW'(4)) && (bit_q < BW'(8));
  wire dummy    = in_stuff && stuff_q[lane];
  wire data_slot = !(in_fas || in_alarm || in_nat || in_ctrl || dummy);

  assign trib_ready  = data_slot ? (4'b0001 << lane) : 4'b0000;
  assign line_bit    = line_q;
  assign frame_start = fs_q;

  always_comb begin
    if (in_fas)         nxt_bit = ALIGN_WORD[fas_idx];
    else if (in_alarm)  nxt_bit = alarm_bit;
    else if (in_nat)    nxt_bit = national_bit;
    else if (in_ctrl)   nxt_bit = stuff_q[lane];
    else if (dummy)     nxt_bit = 1'b1;
    else                nxt_bit = trib_valid[lane] ? trib_data[lane] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q   <= '0;
      set_q   <= '0;
      stuff_q <= '0;
      line_q  <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      bit_q  <= last_bit ? '0 : bit_q + 1'b1;
      if (last_bit) set_q <= set_q + 1'b1;
      if (last_bit && set_q == 2'd0) stuff_q <= stuff_req;
      line_q <= nxt_bit;
      fs_q   <= (set_q == 2'd0) && (bit_q == '0);
    end
  end
endmodule

// File: rtl/pdh_frame_mux_chk.sv
module pdh_frame_mux_chk #(
  parameter int SET_BITS = 212,
  localparam int BW = $clog2(SET_BITS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [BW-1:0] bit_q,
  input logic [1:0]    set_q,
  input logic [3:0]    stuff_q,
  input logic [3:0]    trib_ready,
  input logic          line_bit,
  input logic          frame_start
);
  assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_ready));

  assert_no_grant_overhead_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_q == 2'd0 && bit_q < BW'(12)) || (set_q != 2'd0 && bit_q < BW'(4)))
      |-> trib_ready == 4'b0000);

  assert_stuff_slot_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q == 2'd3 && bit_q >= BW'(4) && bit_q < BW'(8))
      |-> ($countones(trib_ready) == (stuff_q[bit_q[1:0]] ? 0 : 1)));

  assert_stuff_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_q == 2'd1 && bit_q == '0) |-> $stable(stuff_q));

  assert_frame_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_bit);
endmodule

bind pdh_frame_mux pdh_frame_mux_chk #(.SET_BITS(SET_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_q(bit_q), .set_q(set_q), .stuff_q(stuff_q),
  .trib_ready(trib_ready), .line_bit(line_bit), .frame_start(frame_start)
);

// File: tb/tb_pdh_frame_mux.sv
module tb_pdh_frame_mux;
  localparam int SB = 212;
  localparam int FRAMES = 6;

  logic clk = 1'b0;
  logic rst_n, alarm_bit, national_bit, line_bit, frame_start;
  logic [3:0] trib_data, trib_valid, trib_ready, stuff_req;

  always #10 clk = ~clk;

  pdh_frame_mux #(.SET_BITS(SB)) dut (
    .clk(clk), .rst_n(rst_n), .alarm_bit(alarm_bit), .national_bit(national_bit),
    .trib_data(trib_data), .trib_valid(trib_valid), .trib_ready(trib_ready),
    .stuff_req(stuff_req), .line_bit(line_bit), .frame_start(frame_start)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int s = 0, b = 0;
  logic [3:0] mstuff = 4'b0;
  logic exp_line, exp_fs;
  logic [3:0] exp_rdy;
  string tag;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at set %0d bit %0d: actual %b expected %b", req, s + 1, b + 1, act, exp);
    end
  endtask

  // Assemble the model's view of position (s,b), 0-based, with current inputs.
  task automatic model_slot();
    int n;
    logic [9:0] word;
    word = 10'b1111010000;
    n = b % 4;
    exp_rdy = 4'b0;
    if (s == 0 && b < 10) begin exp_line = word[9 - b]; tag = "R2"; end
    else if (s == 0 && b == 10) begin exp_line = alarm_bit; tag = "R3"; end
    else if (s == 0 && b == 11) begin exp_line = national_bit; tag = "R3"; end
    else if (s != 0 && b < 4) begin exp_line = mstuff[n]; tag = "R6"; end
    else if (s == 3 && b >= 4 && b < 8 && mstuff[n]) begin exp_line = 1'b1; tag = "R7"; end
    else begin
      exp_rdy[n] = 1'b1;
      exp_line = trib_valid[n] ? trib_data[n] : 1'b1;
      tag = trib_valid[n] ? "R5" : "R9";
    end
    exp_fs = (s == 0 && b == 0);
  endtask

  task automatic drive();
    alarm_bit    = 1'($urandom);
    national_bit = 1'($urandom);
    trib_data    = 4'($urandom);
    for (int i = 0; i < 4; i++) trib_valid[i] = ($urandom % 10) != 0;
    stuff_req    = 4'($urandom);
  endtask

  initial begin
    rst_n = 1'b0;
    alarm_bit = 0; national_bit = 0; trib_data = 0; trib_valid = 0; stuff_req = 4'hF;
    repeat (3) @(negedge clk);
    check("R10", {3'b0, line_bit}, 4'b0);
    check("R10", {3'b0, frame_start}, 4'b0);
    check("R10", trib_ready, 4'b0);
    rst_n = 1'b1;
    drive();
    model_slot();
    check("R11", trib_ready, exp_rdy);
    for (int cyc = 0; cyc < FRAMES * 4 * SB; cyc++) begin
      @(negedge clk);
      check({tag, "/R4"}, {3'b0, line_bit}, {3'b0, exp_line});
      check("R1", {3'b0, frame_start}, {3'b0, exp_fs});
      if (s == 0 && b == SB - 1) mstuff = stuff_req;   // R8 sampling edge
      b++;
      if (b == SB) begin b = 0; s = (s + 1) % 4; end
      drive();
      model_slot();
      check((s == 3 && b >= 4 && b < 8) ? "R7" : "R5/R11", trib_ready, exp_rdy);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule